// File: doc/BRIEF.md
# Memory Protection Permission Checker

This block sits beside a bus master and judges every access it makes against a small table of address regions. Each region has a base address aligned to its size, a power-of-two size, a valid bit, a 4-bit permission code, a cacheable attribute and a bufferable attribute. For each access the block takes the address, the access kind (data read, data write or instruction fetch) and the privilege level. In the same cycle it reports whether the access is allowed and the winning region's cache and buffer attributes. It also flags a fetch that must not execute and a region whose permission code is undefined.

A denied access raises a one-cycle violation pulse on the next clock edge, tagged with its kind. The first faulting address is held in a fault register until software clears it. Software programs the table through a simple write-only register port. A global enable bit turns all checking off. While it is off, every access is allowed and no violation is raised.

Top module: `mpu_guard`

## Requirements
- R1: After reset the enable bit, every region's valid bit, size, base, permission code, cacheable bit and bufferable bit are zero. So every access is allowed, `acc_cacheable`, `acc_bufferable`, `acc_no_exec` and `acc_code_undef` are 0, and `fault_valid` and `fault_addr` are 0.
- R2: A write (`cfg_we`=1) selects a register by `cfg_addr`:
  - 0x00: enable in bit 0.
  - 0x01: cacheable bits, one per region, region i in bit i.
  - 0x02: bufferable bits, one per region, region i in bit i.
  - 0x03: permission codes, region i in bits [4i+3:4i].
  - 0x04: clears the fault register; the data is ignored.
  - 0x08+i: region i shape, with valid in bit 0 and size field n in bits [5:1].
  - 0x10+i: region i base address.
- R3: With enable clear, every access gives `acc_allow`=1. In that state `acc_cacheable`, `acc_bufferable`, `acc_no_exec` and `acc_code_undef` are 0, and `viol_pulse` stays 0.
- R4: Region i matches an address when it is valid and the address agrees with its base in every bit above bit n, where the region spans 2^(n+1) bytes. The last byte of a region matches it; the first byte past it does not.
- R5: When several regions match, the lowest-numbered one decides the permission and the attributes.
- R6: Permission codes decode as follows (R read, W write, X execute). `acc_kind` 00 is a read, 01 a write, 10 a fetch, and 11 is treated as a read.

  | Code | Privileged | Unprivileged |
  |------|------------|--------------|
  | 0 | R | none |
  | 1 | RX | none |
  | 2 | RW | none |
  | 3 | RWX | none |
  | 4 | R | R |
  | 5 | RX | RX |
  | 6 | RW | RW |
  | 7 | RWX | RWX |
  | 8 | RW | R |
  | 9 | RW | RX |
  | 10 | none | none |

- R7: Codes 11 to 15 deny every access and raise `acc_code_undef` while the enabled block matches such a region.
- R8: When enabled, a valid fetch that is denied drives `acc_no_exec`=1 in the same cycle.
- R9: When enabled, an access that matches no valid region is denied.
- R10: A valid denied access raises `viol_pulse` for exactly the cycle after the one in which it was presented. `viol_kind` then gives the access kind: 01 read, 10 write, 11 fetch.
- R11: The first violation while `fault_valid`=0 loads its address into `fault_addr` and sets `fault_valid`. Later violations leave it unchanged until a write to 0x04 clears both.
- R12: A register write takes effect for an access presented in the cycle right after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register select |
| cfg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | Access presented this cycle |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch |
| acc_priv | input | 1 | 1 for privileged mode |
| acc_allow | output | 1 | Access permitted |
| acc_cacheable | output | 1 | Winning region is cacheable |
| acc_bufferable | output | 1 | Winning region is bufferable |
| acc_no_exec | output | 1 | Denied fetch, do not execute |
| acc_code_undef | output | 1 | Winning region has an undefined code |
| viol_pulse | output | 1 | Registered violation pulse |
| viol_kind | output | 2 | Kind of the pulsed violation |
| fault_valid | output | 1 | Fault register holds an address |
| fault_addr | output | 32 | First faulting address |

## Verification
The bench sweeps all sixteen permission codes against every kind and privilege pair. A decode with one swapped table row would grant unprivileged writes or deny privileged fetches there. It places a small region inside a larger one with different attributes. A priority encoder that picked the highest match would then return the wrong cacheable and bufferable bits. It probes the last byte and the first byte past a region, which catches an off-by-one in the size mask. It also issues a second violation before clearing the fault register and an access right after a register write. A design that overwrote the fault address, or applied writes a cycle late, would report the wrong address or the old permission.

// File: rtl/mpu_pkg.sv
// Shared types and the permission-code decode for the protection checker.
// Assumes a 4-bit permission code per region.
package mpu_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        VK_NONE  = 2'b00,
        VK_READ  = 2'b01,
        VK_WRITE = 2'b10,
        VK_FETCH = 2'b11
    } viol_kind_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

    typedef struct packed {
        rights_t sup;
        rights_t usr;
        logic    bad;
    } perm_t;

    localparam logic [4:0] REG_CTRL  = 5'h00;
    localparam logic [4:0] REG_CACHE = 5'h01;
    localparam logic [4:0] REG_BUF   = 5'h02;
    localparam logic [4:0] REG_PERM  = 5'h03;
    localparam logic [4:0] REG_FCLR  = 5'h04;
    localparam logic [1:0] BANK_SHAPE = 2'b01;
    localparam logic [1:0] BANK_BASE  = 2'b10;

    // Turns a permission code into privileged and unprivileged rights.
    function automatic perm_t decode_perm(input logic [3:0] code);
        perm_t p;
        p = '0;
        case (code)
            4'd0:  p.sup = '{rd: 1'b1, wr: 1'b0, ex: 1'b0};
            4'd1:  p.sup = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
            4'd2:  p.sup = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
            4'd3:  p.sup = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
            4'd4: begin
                p.sup = '{rd: 1'b1, wr: 1'b0, ex: 1'b0};
                p.usr = p.sup;
            end
            4'd5: begin
                p.sup = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
                p.usr = p.sup;
            end
            4'd6: begin
                p.sup = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
                p.usr = p.sup;
            end
            4'd7: begin
                p.sup = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
                p.usr = p.sup;
            end
            4'd8: begin
                p.sup = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
                p.usr = '{rd: 1'b1, wr: 1'b0, ex: 1'b0};
            end
            4'd9: begin
                p.sup = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
                p.usr = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
            end
            4'd10: p = '0;
            default: p.bad = 1'b1;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/mpu_cfg_regs.sv
// Write-only configuration registers: enable, attributes, permission
// codes and region shape/base. Assumes NREG <= 8 so that every
// per-region field fits one 32-bit word and the region banks span eight slots.
module mpu_cfg_regs
    import mpu_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 32,
    parameter int SZW  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [4:0]                cfg_addr,
    input  logic [31:0]               cfg_wdata,
    output logic                      enable,
    output logic [NREG-1:0]           cache_bits,
    output logic [NREG-1:0]           buf_bits,
    output logic [4*NREG-1:0]         perm_codes,
    output logic [NREG-1:0]           reg_valid,
    output logic [NREG-1:0][SZW-1:0]  reg_size,
    output logic [NREG-1:0][AW-1:0]   reg_base,
    output logic                      fault_clr
);

    localparam int PW = 4 * NREG;

    // Decode the one-shot fault clear strobe.
    always_comb fault_clr = cfg_we && (cfg_addr == REG_FCLR);

    // Global registers: enable, attributes and permission codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable     <= 1'b0;
            cache_bits <= '0;
            buf_bits   <= '0;
            perm_codes <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                REG_CTRL:  enable     <= cfg_wdata[0];
                REG_CACHE: cache_bits <= cfg_wdata[NREG-1:0];
                REG_BUF:   buf_bits   <= cfg_wdata[NREG-1:0];
                REG_PERM:  perm_codes <= cfg_wdata[PW-1:0];
                default: ;
            endcase
        end
    end

    // Per-region shape and base registers, one slot each.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reg_valid[g] <= 1'b0;
                reg_size[g]  <= '0;
                reg_base[g]  <= '0;
            end else if (cfg_we && cfg_addr[2:0] == 3'(g)) begin
                if (cfg_addr[4:3] == BANK_SHAPE) begin
                    reg_valid[g] <= cfg_wdata[0];
                    reg_size[g]  <= cfg_wdata[SZW:1];
                end else if (cfg_addr[4:3] == BANK_BASE) begin
                    reg_base[g]  <= cfg_wdata[AW-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/mpu_region_match.sv
// Compares an address with every region and picks the lowest-numbered
// hit. Assumes bases are aligned to their size; bits below the region
// size are ignored in the compare.
module mpu_region_match #(
    parameter int NREG = 8,
    parameter int AW   = 32,
    parameter int SZW  = 5,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [AW-1:0]             addr,
    input  logic [NREG-1:0]           reg_valid,
    input  logic [NREG-1:0][SZW-1:0]  reg_size,
    input  logic [NREG-1:0][AW-1:0]   reg_base,
    output logic                      hit,
    output logic [IW-1:0]             hit_idx
);

    logic [NREG-1:0] hits;

    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        logic [AW-1:0] mask;
        // Mask keeps the address bits above the region size.
        always_comb mask = {AW{1'b1}} << ({1'b0, reg_size[g]} + 1'b1);
        // Region hit when valid and the upper bits agree.
        always_comb hits[g] = reg_valid[g] && ((addr & mask) == (reg_base[g] & mask));
    end

    // Lowest-numbered hit wins.
    always_comb begin
        hit     = |hits;
        hit_idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (hits[i]) hit_idx = IW'(i);
        end
    end

endmodule

// File: rtl/mpu_rights.sv
// Checks one access kind and privilege against a permission code.
// Assumes kind 11 is handled as a data read.
module mpu_rights
    import mpu_pkg::*;
(
    input  logic [3:0] code,
    input  logic [1:0] kind,
    input  logic       priv,
    output logic       granted,
    output logic       undef_code
);

    perm_t   p;
    rights_t r;

    // Decode the code and pick the privilege column.
    always_comb begin
        p          = decode_perm(code);
        r          = priv ? p.sup : p.usr;
        undef_code = p.bad;
    end

    // Select the right that the access kind needs.
    always_comb begin
        case (acc_kind_e'(kind))
            ACC_WRITE: granted = r.wr;
            ACC_FETCH: granted = r.ex;
            default:   granted = r.rd;
        endcase
    end

endmodule

// File: rtl/mpu_fault.sv
// Registers the violation pulse and kind, and holds the first fault
// address until cleared. A clear and a new violation in one cycle
// leave the new address captured.
module mpu_fault
    import mpu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          viol,
    input  logic [1:0]    kind,
    input  logic [AW-1:0] addr,
    input  logic          fault_clr,
    output logic          viol_pulse,
    output logic [1:0]    viol_kind,
    output logic          fault_valid,
    output logic [AW-1:0] fault_addr
);

    logic [1:0] kind_code;

    // Map the access kind onto the violation kind code.
    always_comb begin
        case (acc_kind_e'(kind))
            ACC_WRITE: kind_code = VK_WRITE;
            ACC_FETCH: kind_code = VK_FETCH;
            default:   kind_code = VK_READ;
        endcase
    end

    // One-cycle pulse and its kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_pulse <= 1'b0;
            viol_kind  <= VK_NONE;
        end else begin
            viol_pulse <= viol;
            viol_kind  <= viol ? kind_code : VK_NONE;
        end
    end

    // Sticky fault address with software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_valid <= 1'b0;
            fault_addr  <= '0;
        end else if (viol && (!fault_valid || fault_clr)) begin
            fault_valid <= 1'b1;
            fault_addr  <= addr;
        end else if (fault_clr) begin
            fault_valid <= 1'b0;
            fault_addr  <= '0;
        end
    end

endmodule

// File: rtl/mpu_guard.sv
// Top of the protection checker: configuration, region match, rights
// check and fault capture. Results are combinational in the access
// cycle; the violation pulse follows one cycle later.
module mpu_guard
    import mpu_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 32,
    localparam int SZW = $clog2(AW),
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [4:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    input  logic          acc_valid,
    input  logic [AW-1:0] acc_addr,
    input  logic [1:0]    acc_kind,
    input  logic          acc_priv,
    output logic          acc_allow,
    output logic          acc_cacheable,
    output logic          acc_bufferable,
    output logic          acc_no_exec,
    output logic          acc_code_undef,
    output logic          viol_pulse,
    output logic [1:0]    viol_kind,
    output logic          fault_valid,
    output logic [AW-1:0] fault_addr
);

    logic                     ctl_enable;
    logic [NREG-1:0]          cache_bits;
    logic [NREG-1:0]          buf_bits;
    logic [4*NREG-1:0]        perm_codes;
    logic [NREG-1:0]          reg_valid;
    logic [NREG-1:0][SZW-1:0] reg_size;
    logic [NREG-1:0][AW-1:0]  reg_base;
    logic                     fault_clr;
    logic                     hit;
    logic [IW-1:0]            hit_idx;
    logic [3:0]               win_code;
    logic                     granted;
    logic                     undef_code;
    logic                     viol;

    mpu_cfg_regs #(.NREG(NREG), .AW(AW), .SZW(SZW)) i_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .enable     (ctl_enable),
        .cache_bits (cache_bits),
        .buf_bits   (buf_bits),
        .perm_codes (perm_codes),
        .reg_valid  (reg_valid),
        .reg_size   (reg_size),
        .reg_base   (reg_base),
        .fault_clr  (fault_clr)
    );

    mpu_region_match #(.NREG(NREG), .AW(AW), .SZW(SZW)) i_match (
        .addr      (acc_addr),
        .reg_valid (reg_valid),
        .reg_size  (reg_size),
        .reg_base  (reg_base),
        .hit       (hit),
        .hit_idx   (hit_idx)
    );

    // Pick the permission code of the winning region.
    always_comb win_code = perm_codes[4*hit_idx +: 4];

    mpu_rights i_rights (
        .code       (win_code),
        .kind       (acc_kind),
        .priv       (acc_priv),
        .granted    (granted),
        .undef_code (undef_code)
    );

    // Combine enable, match and rights into the access verdict.
    always_comb begin
        acc_allow      = !ctl_enable || (hit && granted);
        acc_cacheable  = ctl_enable && hit && cache_bits[hit_idx];
        acc_bufferable = ctl_enable && hit && buf_bits[hit_idx];
        acc_code_undef = ctl_enable && hit && undef_code;
        acc_no_exec    = ctl_enable && acc_valid && !acc_allow
                         && (acc_kind == ACC_FETCH);
        viol           = acc_valid && !acc_allow;
    end

    mpu_fault #(.AW(AW)) i_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .viol        (viol),
        .kind        (acc_kind),
        .addr        (acc_addr),
        .fault_clr   (fault_clr),
        .viol_pulse  (viol_pulse),
        .viol_kind   (viol_kind),
        .fault_valid (fault_valid),
        .fault_addr  (fault_addr)
    );

endmodule

// File: rtl/mpu_guard_chk.sv
// Property checker for mpu_guard, bound to every instance of it.
module mpu_guard_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          fault_clr,
    input logic          acc_valid,
    input logic [1:0]    acc_kind,
    input logic          acc_allow,
    input logic          acc_no_exec,
    input logic          acc_code_undef,
    input logic          viol_pulse,
    input logic [1:0]    viol_kind,
    input logic          fault_valid,
    input logic [AW-1:0] fault_addr
);

    a_r3_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !enable) |=> !viol_pulse);

    a_r10_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_allow) |=> viol_pulse);

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_allow) |=> !viol_pulse);

    a_r10_fetch_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_allow && acc_kind == 2'b10) |=> (viol_kind == 2'b11));

    a_r7_undef_denied: assert property (@(posedge clk) disable iff (!rst_n)
        acc_code_undef |-> !acc_allow);

    a_r8_noexec_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        acc_no_exec |-> (acc_valid && acc_kind == 2'b10 && enable));

    a_r11_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && !fault_clr) |=> (fault_valid && $stable(fault_addr)));

endmodule

bind mpu_guard mpu_guard_chk #(.AW(AW)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable         (ctl_enable),
    .fault_clr      (fault_clr),
    .acc_valid      (acc_valid),
    .acc_kind       (acc_kind),
    .acc_allow      (acc_allow),
    .acc_no_exec    (acc_no_exec),
    .acc_code_undef (acc_code_undef),
    .viol_pulse     (viol_pulse),
    .viol_kind      (viol_kind),
    .fault_valid    (fault_valid),
    .fault_addr     (fault_addr)
);

// File: tb/test_mpu_guard.sv
// Scoreboard bench: access tasks push expected pulses, a monitor pops them.
module test_mpu_guard;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        acc_priv = 1'b0;
    logic        acc_allow, acc_cacheable, acc_bufferable, acc_no_exec, acc_code_undef;
    logic        viol_pulse, fault_valid;
    logic [1:0]  viol_kind;
    logic [31:0] fault_addr;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  model_en = 0;
    bit  mon_on = 0;

    typedef struct {
        bit         pulse;
        logic [1:0] kind;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mpu_guard i_mpu_guard (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_kind(acc_kind), .acc_priv(acc_priv), .acc_allow(acc_allow),
        .acc_cacheable(acc_cacheable), .acc_bufferable(acc_bufferable),
        .acc_no_exec(acc_no_exec), .acc_code_undef(acc_code_undef),
        .viol_pulse(viol_pulse), .viol_kind(viol_kind),
        .fault_valid(fault_valid), .fault_addr(fault_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Table of rights per code from the requirement text: {pr,pw,px,ur,uw,ux}.
    function automatic bit exp_ok(input int code, input bit priv, input int kind);
        bit [5:0] t;
        case (code)
            0: t = 6'b100_000;
            1: t = 6'b101_000;
            2: t = 6'b110_000;
            3: t = 6'b111_000;
            4: t = 6'b100_100;
            5: t = 6'b101_101;
            6: t = 6'b110_110;
            7: t = 6'b111_111;
            8: t = 6'b110_100;
            9: t = 6'b110_101;
            default: t = 6'b000_000;
        endcase
        if (!priv) t = {t[2:0], 3'b000};
        case (kind)
            1: return t[4];
            2: return t[3];
            default: return t[5];
        endcase
    endfunction

    task automatic cfg_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b0;
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        if (a == 5'h00) model_en = d[0];
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_we    = 1'b0;
            acc_valid = 1'b0;
        end
    endtask

    // Drive one access, check the same-cycle outputs, queue the pulse.
    task automatic do_acc(input logic [31:0] a, input int k, input bit p,
                          input bit e_allow, input bit e_c, input bit e_b,
                          input bit e_undef, input string tag);
        exp_t e;
        @(negedge clk);
        cfg_we    = 1'b0;
        acc_valid = 1'b1;
        acc_addr  = a;
        acc_kind  = k[1:0];
        acc_priv  = p;
        #1;
        chk({tag, " allow"}, 32'(acc_allow), 32'(e_allow));
        chk({tag, " cacheable"}, 32'(acc_cacheable), 32'(e_c));
        chk({tag, " bufferable"}, 32'(acc_bufferable), 32'(e_b));
        chk({tag, " undef"}, 32'(acc_code_undef), 32'(e_undef));
        chk({tag, " R8 no_exec"}, 32'(acc_no_exec), 32'(model_en && k == 2 && !e_allow));
        e.pulse = !e_allow;
        e.kind  = (k == 2) ? 2'b11 : (k == 1) ? 2'b10 : 2'b01;
        e.tag   = {tag, " R10 pulse"};
        sb.push_back(e);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // Monitor: after each edge, compare the pulse against the scoreboard.
    always @(posedge clk) begin
        exp_t it;
        #2;
        if (mon_on) begin
            if (sb.size() > 0) begin
                it = sb.pop_front();
                chk(it.tag, 32'(viol_pulse), 32'(it.pulse));
                if (it.pulse) chk({it.tag, " kind"}, 32'(viol_kind), 32'(it.kind));
            end else if (viol_pulse !== 1'b0) begin
                chk("R10 idle pulse", 32'(viol_pulse), 32'd0);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1;

        // R1: reset state, block disabled.
        chk("R1 fault_valid", 32'(fault_valid), 32'd0);
        chk("R1 fault_addr", fault_addr, 32'd0);
        do_acc(32'h5000, 2, 0, 1, 0, 0, 0, "R1 reset fetch");

        // Regions: 0 at 0x1000 (4 KiB), 1 at 0 (64 KiB), 2 at 0x40000 (256 B).
        cfg_wr(5'h10, 32'h0000_1000); cfg_wr(5'h08, {26'd0, 5'd11, 1'b1});
        cfg_wr(5'h11, 32'h0000_0000); cfg_wr(5'h09, {26'd0, 5'd15, 1'b1});
        cfg_wr(5'h12, 32'h0004_0000); cfg_wr(5'h0A, {26'd0, 5'd7, 1'b1});
        cfg_wr(5'h01, 32'h1);          // region 0 cacheable
        cfg_wr(5'h02, 32'h2);          // region 1 bufferable
        cfg_wr(5'h03, 32'h0000_0770);  // codes r0=0 r1=7 r2=7
        idle(1);

        // R3: still disabled, a no-access region and a miss are allowed.
        do_acc(32'h1234, 1, 0, 1, 0, 0, 0, "R3 disabled write");
        do_acc(32'h9000_0000, 2, 0, 1, 0, 0, 0, "R3 disabled miss");

        cfg_wr(5'h00, 32'h1);
        idle(1);

        // R6/R7/R5: sweep every code on region 0 (inside region 1).
        for (int c = 0; c < 16; c++) begin
            cfg_wr(5'h03, 32'h0000_0770 | c);
            for (int pv = 0; pv < 2; pv++) begin
                for (int k = 0; k < 3; k++) begin
                    do_acc(32'h1234, k, pv[0], exp_ok(c, pv[0], k), 1, 0, c > 10,
                           $sformatf("R6 code%0d priv%0d kind%0d", c, pv, k));
                end
            end
        end

        // R5: region 1 only, its attributes and full rights.
        do_acc(32'h2000, 1, 0, 1, 0, 1, 0, "R5 outer region");

        // R4: region 2 edges.
        cfg_wr(5'h03, 32'h0000_0777);
        do_acc(32'h0004_00FF, 0, 0, 1, 0, 0, 0, "R4 last byte");
        do_acc(32'h0004_0100, 0, 0, 0, 0, 0, 0, "R4 first byte past R9");

        // R11: clear fault register, capture, hold, clear, recapture.
        cfg_wr(5'h04, 32'h0);
        idle(1);
        chk("R11 cleared", 32'(fault_valid), 32'd0);
        do_acc(32'h0008_0000, 1, 1, 0, 0, 0, 0, "R9 miss write");
        chk("R11 capture", fault_addr, 32'h0008_0000);
        chk("R11 valid", 32'(fault_valid), 32'd1);
        do_acc(32'h0009_0000, 2, 1, 0, 0, 0, 0, "R9 miss fetch");
        chk("R11 hold", fault_addr, 32'h0008_0000);
        cfg_wr(5'h04, 32'h0);
        idle(1);
        chk("R11 clear valid", 32'(fault_valid), 32'd0);
        chk("R11 clear addr", fault_addr, 32'd0);
        do_acc(32'h000A_0000, 0, 0, 0, 0, 0, 0, "R9 miss read");
        chk("R11 recapture", fault_addr, 32'h000A_0000);

        // R12: write takes effect in the very next access cycle.
        cfg_wr(5'h03, 32'h0000_077A);
        do_acc(32'h1100, 0, 1, 0, 1, 0, 0, "R12 new code 10");
        cfg_wr(5'h03, 32'h0000_0777);
        do_acc(32'h1100, 0, 0, 1, 1, 0, 0, "R12 code 7 again");

        // R2: disable region 0 shape; address falls to region 1.
        cfg_wr(5'h08, 32'h0);
        do_acc(32'h1100, 0, 0, 1, 0, 1, 0, "R2 region0 invalid");

        // R3: disable suppresses exceptions on a miss.
        cfg_wr(5'h00, 32'h0);
        do_acc(32'h0F00_0000, 2, 0, 1, 0, 0, 0, "R3 disabled again");

        idle(3);
        chk("R10 scoreboard drained", 32'(sb.size()), 32'd0);
        finish_run();
    end

endmodule